// File: doc/BRIEF.md
# Iterative Integer Divider With Remainder

This block divides two 32-bit integers over several clock cycles and returns either the quotient or the remainder. A two-bit operation select picks signed or unsigned arithmetic and quotient or remainder. A one-cycle `start` strobe hands the operands in. `busy` stays high while the work is in progress. A one-cycle `done` pulse marks the cycle in which `result` becomes valid. Signed requests are converted to magnitudes and run through an unsigned radix-2 restoring core. A final cycle then puts the signs back.

No exception exists. Division by zero and the single signed overflow case (most-negative value divided by minus one) are recognised in the setup cycle, and a fixed result comes back at once. The block also keeps the remainder of the most recent completed quotient request. A remainder request that directly follows it, with the same operands and the same signedness, is answered from that saved value without a new iteration run. This speeds up the usual pattern of fetching a quotient and then its remainder.

Top module: `intDivider`

## Requirements
- R1: `opSel[1]`=1 selects signed, 0 unsigned. `opSel[0]`=1 selects remainder, 0 quotient. The quotient truncates toward zero in both modes.
- R2: A signed remainder has the sign of the dividend, and dividend = divisor × quotient + remainder holds modulo 2^32.
- R3: With a zero divisor, the quotient is 0xFFFFFFFF and the remainder equals the dividend, in both signed and unsigned mode.
- R4: Signed 0x80000000 divided by 0xFFFFFFFF (-1) gives quotient 0x80000000 and remainder 0.
- R5: Unsigned division never overflows. For example, 0x80000000 / 0xFFFFFFFF unsigned gives quotient 0 and remainder 0x80000000.
- R6: A regular request accepted at clock edge k raises `done` after edge k+34: one setup cycle, 32 iteration cycles and one sign-fixup cycle. `busy` is high from edge k until `done` rises.
- R7: Zero-divisor and signed-overflow requests raise `done` after edge k+1.
- R8: A remainder request whose operands and signedness match the immediately preceding completed request, when that request was a quotient, returns the saved remainder with `done` after edge k+1. Any other remainder request takes the full latency.
- R9: `start` is ignored while `busy` is high. The running request and its result are unaffected.
- R10: `done` is high for exactly one cycle. `result` changes only in a cycle in which `done` rises and holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| opSel | input | 2 | [1] signed, [0] remainder |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Quotient or remainder |

## Verification
Random operands cover all four sign combinations in signed mode, which shows whether truncation and the remainder sign are handled on each path. Small random divisors mixed with full-width ones exercise both long and short quotients in the restoring core. Directed pairs hit the zero divisor, the most-negative by minus one case in both signedness modes, and quotient-then-remainder sequences with matching and mismatching signedness. These separate the fast paths from the full 34-cycle path by measured latency. A `start` pulse injected mid-run with different operands shows whether a busy request can be disturbed.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } divState_e;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic capture;     // latch operands and op select
    logic init;        // load magnitudes into the core
    logic step;        // one restoring iteration
    logic finNormal;   // publish sign-fixed core result
    logic finSpecial;  // publish fixed zero-divisor / overflow result
    logic finReuse;    // publish saved remainder
  } divStrobes_t;
endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isSpecial,
  input  logic        reuseHit,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  divState_e state;
  logic [CNT_W-1:0] count;

  always_comb begin
    strobes = '0;
    unique case (state)
      ST_IDLE:  strobes.capture = start;
      ST_SETUP: begin
        strobes.finReuse   = reuseHit;
        strobes.finSpecial = !reuseHit && isSpecial;
        strobes.init       = !reuseHit && !isSpecial;
      end
      ST_ITER:  strobes.step = 1'b1;
      ST_FIX:   strobes.finNormal = 1'b1;
      default:  strobes = '0;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobes.finNormal | strobes.finSpecial | strobes.finReuse;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_SETUP;
        ST_SETUP: begin
          count <= '0;
          state <= strobes.init ? ST_ITER : ST_IDLE;
        end
        ST_ITER: begin
          count <= count + 1'b1;
          if (count == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_fix_after_iter_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITER && count == LAST_STEP) |=> (state == ST_FIX));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (state != ST_SETUP));
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             isSpecial,
  output logic             reuseHit,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] aReg, bReg;
  logic             sgnReg, remOpReg;
  logic [WIDTH-1:0] magB, remAcc, quoAcc;
  logic             negQ, negR;
  logic [WIDTH-1:0] lastA, lastB, savedRem;
  logic             lastSgn, lastValid;

  logic             zeroDiv, overflow;
  logic [WIDTH-1:0] magA, magBNext;
  logic [WIDTH:0]   shifted, diff;
  logic [WIDTH-1:0] fixQ, fixR, spQ, spR, finalQ, finalR;
  logic             finishAny;

  assign zeroDiv   = (bReg == '0);
  assign overflow  = sgnReg && (aReg == MOST_NEG) && (bReg == ALL_ONES);
  assign isSpecial = zeroDiv || overflow;
  assign reuseHit  = remOpReg && lastValid && (lastA == aReg) &&
                     (lastB == bReg) && (lastSgn == sgnReg);

  assign magA     = (sgnReg && aReg[WIDTH-1]) ? -aReg : aReg;
  assign magBNext = (sgnReg && bReg[WIDTH-1]) ? -bReg : bReg;

  assign shifted = {remAcc, quoAcc[WIDTH-1]};
  assign diff    = shifted - {1'b0, magB};

  assign fixQ   = negQ ? -quoAcc : quoAcc;
  assign fixR   = negR ? -remAcc : remAcc;
  assign spQ    = zeroDiv ? ALL_ONES : aReg;
  assign spR    = zeroDiv ? aReg : '0;
  assign finalQ = strobes.finSpecial ? spQ : fixQ;
  assign finalR = strobes.finSpecial ? spR : fixR;
  assign finishAny = strobes.finNormal | strobes.finSpecial | strobes.finReuse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0; sgnReg <= 1'b0; remOpReg <= 1'b0;
      magB <= '0; remAcc <= '0; quoAcc <= '0; negQ <= 1'b0; negR <= 1'b0;
      lastA <= '0; lastB <= '0; lastSgn <= 1'b0; lastValid <= 1'b0;
      savedRem <= '0; result <= '0;
    end else begin
      if (strobes.capture) begin
        aReg     <= dividend;
        bReg     <= divisor;
        sgnReg   <= opSel[1];
        remOpReg <= opSel[0];
      end
      if (strobes.init) begin
        magB   <= magBNext;
        remAcc <= '0;
        quoAcc <= magA;
        negQ   <= sgnReg && (aReg[WIDTH-1] ^ bReg[WIDTH-1]);
        negR   <= sgnReg && aReg[WIDTH-1];
      end
      if (strobes.step) begin
        if (!diff[WIDTH]) begin
          remAcc <= diff[WIDTH-1:0];
          quoAcc <= {quoAcc[WIDTH-2:0], 1'b1};
        end else begin
          remAcc <= shifted[WIDTH-1:0];
          quoAcc <= {quoAcc[WIDTH-2:0], 1'b0};
        end
      end
      if (strobes.finReuse) begin
        result    <= savedRem;
        lastValid <= 1'b0;
      end else if (strobes.finNormal || strobes.finSpecial) begin
        result    <= remOpReg ? finalR : finalQ;
        lastValid <= !remOpReg;
        if (!remOpReg) begin
          lastA    <= aReg;
          lastB    <= bReg;
          lastSgn  <= sgnReg;
          savedRem <= finalR;
        end
      end
    end
  end

  // restoring invariant: partial remainder stays below the divisor magnitude
  assert_partial_rem_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && magB != '0) |=> (remAcc < magB));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !finishAny |=> $stable(result));

  assert_one_finish_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.finNormal, strobes.finSpecial, strobes.finReuse}) <= 1);
endmodule

// File: rtl/intDivider.sv
module intDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  divStrobes_t strobes;
  logic        isSpecial;
  logic        reuseHit;

  divControl #(.WIDTH(WIDTH)) u_control (
    .clk(clk), .rstN(rstN), .start(start),
    .isSpecial(isSpecial), .reuseHit(reuseHit),
    .strobes(strobes), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opSel(opSel), .dividend(dividend), .divisor(divisor),
    .isSpecial(isSpecial), .reuseHit(reuseHit), .result(result)
  );
endmodule

// File: tb/intDivider_tb.sv
module intDivider_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = '0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  logic        tbLastValid = 1'b0;
  logic [31:0] tbLastA = '0, tbLastB = '0;
  logic        tbLastSgn = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  intDivider u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] refDiv(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 32'd0) return op[0] ? a : 32'hFFFF_FFFF;
    if (op[1] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return op[0] ? 32'd0 : a;
    if (op[1]) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
    end else begin
      sa = longint'({32'd0, a});
      sb = longint'({32'd0, b});
    end
    q = sa / sb;
    r = sa % sb;
    return op[0] ? r[31:0] : q[31:0];
  endfunction

  function automatic int refLatency(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (b == 32'd0) return 1;
    if (op[1] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 1;
    if (op[0] && tbLastValid && tbLastA == a && tbLastB == b && tbLastSgn == op[1]) return 1;
    return 34;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // run one request; optionally pulse start mid-run with other operands (R9)
  task automatic runOp(input string req, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit poke);
    logic [31:0] expRes;
    int expLat, n;
    expRes = refDiv(op, a, b);
    expLat = refLatency(op, a, b);
    @(negedge clk);
    start = 1'b1; opSel = op; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      if (poke && n == 5) begin
        start = 1'b1; opSel = ~op; dividend = ~a; divisor = 32'd3;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check(req, "result", result, expRes);
    check(expLat == 1 ? "R7/R8" : "R6", "latency", 32'(n), 32'(expLat));
    check("R6", "busy low at done", {31'd0, busy}, 32'd0);
    tbLastValid = !op[0];
    if (!op[0]) begin
      tbLastA = a; tbLastB = b; tbLastSgn = op[1];
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "reset result", result, 32'd0);
    check("R10", "reset done", {31'd0, done}, 32'd0);
    check("R6", "reset busy", {31'd0, busy}, 32'd0);

    // R1 truncation toward zero, all sign combinations
    runOp("R1", 2'b10, 32'd7, 32'd2, 0);
    runOp("R1", 2'b10, -32'sd7, 32'd2, 0);
    runOp("R1", 2'b10, 32'd7, -32'sd2, 0);
    runOp("R1", 2'b10, -32'sd7, -32'sd2, 0);
    runOp("R1", 2'b00, 32'hFFFF_FFF9, 32'd2, 0);
    // R2 remainder sign follows dividend
    runOp("R2", 2'b11, -32'sd7, 32'd2, 0);
    runOp("R2", 2'b11, 32'd7, -32'sd2, 0);
    // R3 zero divisor
    runOp("R3", 2'b00, 32'd55, 32'd0, 0);
    runOp("R3", 2'b10, -32'sd55, 32'd0, 0);
    runOp("R3", 2'b11, -32'sd55, 32'd0, 0);
    runOp("R3", 2'b01, 32'd55, 32'd0, 0);
    // R4 signed overflow
    runOp("R4", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    runOp("R4", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    // R5 unsigned of same bits
    runOp("R5", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    runOp("R5", 2'b01, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    // R8 reuse path and its misses
    runOp("R8", 2'b10, -32'sd1000, 32'd7, 0);
    runOp("R8", 2'b11, -32'sd1000, 32'd7, 0);
    runOp("R8", 2'b00, 32'd1000, 32'd7, 0);
    runOp("R8", 2'b11, 32'd1000, 32'd7, 0);
    runOp("R8", 2'b00, 32'd999, 32'd5, 0);
    runOp("R8", 2'b01, 32'd12, 32'd5, 0);
    runOp("R8", 2'b01, 32'd999, 32'd5, 0);
    // R9 start while busy ignored
    runOp("R9", 2'b10, 32'd123456, -32'sd321, 1);
    runOp("R9", 2'b01, 32'hDEAD_BEEF, 32'd17, 1);
    // R10 result held and done drops
    held = result;
    repeat (4) @(negedge clk);
    check("R10", "result held", result, held);
    check("R10", "done pulse", {31'd0, done}, 32'd0);

    // random mix (R1, R2)
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      logic [31:0] a, b;
      op = 2'($urandom_range(0, 3));
      a = $urandom;
      b = (i % 3 == 0) ? 32'($urandom_range(1, 20)) : $urandom;
      if (i % 3 == 1) b = -b;
      runOp(op[0] ? "R2" : "R1", op, a, b, 0);
      if (i % 5 == 0) runOp("R8", {op[1], 1'b1}, a, b, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule